// File: doc/BRIEF.md
# Two-Clock Port Access Control with Mailbox Exchange

This block sits between two independently clocked 36-bit ports and a pair of FIFOs that carry data in opposite directions. FIFO1 runs from port A to port B, and FIFO2 runs from port B to port A. On each port it turns four control lines into exactly one kind of access, or none. The control lines are an active-low select, a direction line, an enable and a mailbox select. The four kinds of access are a FIFO write, a FIFO read, a mailbox write and a mailbox read. FIFO storage is outside the block. Each port sees its FIFO through a write strobe with an input-ready signal, and a read strobe with an output-ready signal and a read-data bus.

When the mailbox select is high, an access bypasses the FIFOs and uses one of two mail registers instead. Port A writes into mailbox 1, which port B reads. Port B writes into mailbox 2, which port A reads. Each mailbox has a "mail waiting" flag in the clock domain of its reader. A write sets the flag, and a read by the other port clears it. The set and clear events cross between the clocks as toggles that pass through synchronizers.

Top module: `bidir_port_ctrl`

## Requirements
- R1: On port A, `a_f1_wr` is high exactly when `a_cs_n`=0, `a_wr_rd`=1 (write), `a_en`=1, `a_mb`=0 and `a_f1_in_rdy`=1.
- R2: On port A, `a_f2_rd` is high exactly when `a_cs_n`=0, `a_wr_rd`=0 (read), `a_en`=1, `a_mb`=0 and `a_f2_out_rdy`=1.
- R3: Port B uses the opposite direction polarity: `b_wr_rd`=0 means write and 1 means read. `b_f2_wr` and `b_f1_rd` otherwise follow the same conditions as R1 and R2, using `b_f2_in_rdy` and `b_f1_out_rdy`.
- R4: A port's `*_dout_oe` is high exactly when its select is low and the port is in read mode. While it is low, that port's `*_dout` is all zeros.
- R5: While a port drives its output, `*_dout` shows the incoming mail register when `*_mb`=1, and shows the FIFO read data when `*_mb`=0.
- R6: A mailbox write (select low, write mode, enable high, `*_mb`=1) loads the outgoing mail register with `*_din`. The reader's flag (`b_mb1_full` or `a_mb2_full`) then rises no later than the third reader clock edge after the writing edge.
- R7: A mailbox read with the flag high clears the flag at that reader clock edge. The mail word then still reads back unchanged.
- R8: A mailbox write made while the previous word is still unread is ignored, and the old word is kept.
- R9: Once the reader has cleared the flag, the writer's next mailbox write is accepted if it comes at least three writer clock edges after the clearing edge. Repeated exchanges in both directions deliver every word in order.
- R10: After the synchronous active-high reset, both mail flags are low and both mail registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_cs_n | input | 1 | Port A select, active low |
| a_wr_rd | input | 1 | Port A direction, 1 = write, 0 = read |
| a_en | input | 1 | Port A access enable |
| a_mb | input | 1 | Port A mailbox select |
| a_din | input | W | Port A write data |
| a_dout | output | W | Port A read data |
| a_dout_oe | output | 1 | Port A output drive enable |
| a_f1_wr | output | 1 | FIFO1 write strobe |
| a_f1_in_rdy | input | 1 | FIFO1 has room |
| a_f2_rd | output | 1 | FIFO2 read strobe |
| a_f2_out_rdy | input | 1 | FIFO2 has a word ready |
| a_f2_rdata | input | W | FIFO2 output word |
| a_mb2_full | output | 1 | Mailbox 2 holds unread mail (clk_a domain) |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_cs_n | input | 1 | Port B select, active low |
| b_wr_rd | input | 1 | Port B direction, 0 = write, 1 = read |
| b_en | input | 1 | Port B access enable |
| b_mb | input | 1 | Port B mailbox select |
| b_din | input | W | Port B write data |
| b_dout | output | W | Port B read data |
| b_dout_oe | output | 1 | Port B output drive enable |
| b_f2_wr | output | 1 | FIFO2 write strobe |
| b_f2_in_rdy | input | 1 | FIFO2 has room |
| b_f1_rd | output | 1 | FIFO1 read strobe |
| b_f1_out_rdy | input | 1 | FIFO1 has a word ready |
| b_f1_rdata | input | W | FIFO1 output word |
| b_mb1_full | output | 1 | Mailbox 1 holds unread mail (clk_b domain) |

## Verification
The mailbox assertions assume that both resets are applied together and held across several edges of both clocks, so that the set and clear toggles start out equal. They also assume the two clocks are free-running, so that the synchronizers keep making progress. The bench releases both resets at the same time and waits at least four edges of the other clock before it relies on a toggle having crossed. The decode assertions hold for any input pattern, and the bench feeds every one of the 64 control and ready combinations on each port while the other port stays idle.

// File: rtl/bififo_pkg.sv
package bififo_pkg;
  typedef struct packed {
    logic fifo_wr;
    logic fifo_rd;
    logic mail_wr;
    logic mail_rd;
    logic drive;
  } port_op_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int TOP = STAGES - 1;
  logic [TOP:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[TOP-1:0], d};
      end
    end
  endgenerate

  assign q = sr[TOP];
endmodule

// File: rtl/port_decode.sv
module port_decode
  import bififo_pkg::*;
#(
  parameter bit WR_LEVEL = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cs_n,
  input  logic     wr_rd,
  input  logic     en,
  input  logic     mb,
  input  logic     in_rdy,
  input  logic     out_rdy,
  output port_op_t op
);
  logic sel, is_wr, go;

  always_comb begin
    sel        = !cs_n;
    is_wr      = (wr_rd == WR_LEVEL);
    go         = sel && en;
    op.fifo_wr = go && is_wr && !mb && in_rdy;
    op.fifo_rd = go && !is_wr && !mb && out_rdy;
    op.mail_wr = go && is_wr && mb;
    op.mail_rd = go && !is_wr && mb;
    op.drive   = sel && !is_wr;
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op.fifo_wr, op.fifo_rd, op.mail_wr, op.mail_rd})); // R1
  AST_WRITE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
    op.fifo_wr |-> in_rdy); // R1
  AST_READ_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
    op.fifo_rd |-> out_rdy); // R2
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op.fifo_wr || op.mail_wr) |-> !op.drive); // R4
endmodule

// File: rtl/mailbox_xfer.sv
module mailbox_xfer #(
  parameter int W           = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         rd_req,
  output logic [W-1:0] rdata,
  output logic         rfull
);
  logic [W-1:0] mail_q;
  logic set_tog, clr_tog, set_tog_r, clr_tog_w, wbusy;

  sync_chain #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk(rclk), .rst(rrst), .d(set_tog), .q(set_tog_r));
  sync_chain #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(wclk), .rst(wrst), .d(clr_tog), .q(clr_tog_w));

  // writer side: busy until the reader's clear toggle comes back
  assign wbusy = set_tog ^ clr_tog_w;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      mail_q  <= '0;
      set_tog <= 1'b0;
    end else if (wr_req && !wbusy) begin
      mail_q  <= wdata;
      set_tog <= ~set_tog;
    end
  end

  // reader side: flag is the difference of the two toggles
  assign rfull = set_tog_r ^ clr_tog;

  always_ff @(posedge rclk) begin
    if (rrst)                  clr_tog <= 1'b0;
    else if (rd_req && rfull)  clr_tog <= ~clr_tog;
  end

  assign rdata = mail_q;

  AST_FLAG_CLEARS: assert property (@(posedge rclk) disable iff (rrst)
    (rd_req && rfull) |=> !rfull); // R7
  AST_BUSY_HOLDS_MAIL: assert property (@(posedge wclk) disable iff (wrst)
    (wr_req && wbusy) |=> $stable(mail_q)); // R8
  AST_MAIL_STABLE_WHILE_FULL: assert property (@(posedge rclk) disable iff (rrst)
    (rfull && $past(rfull)) |-> $stable(mail_q)); // R6
endmodule

// File: rtl/bidir_port_ctrl.sv
module bidir_port_ctrl
  import bififo_pkg::*;
#(
  parameter int W           = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_a,
  input  logic         rst_a,
  input  logic         a_cs_n,
  input  logic         a_wr_rd,
  input  logic         a_en,
  input  logic         a_mb,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         a_dout_oe,
  output logic         a_f1_wr,
  input  logic         a_f1_in_rdy,
  output logic         a_f2_rd,
  input  logic         a_f2_out_rdy,
  input  logic [W-1:0] a_f2_rdata,
  output logic         a_mb2_full,
  input  logic         clk_b,
  input  logic         rst_b,
  input  logic         b_cs_n,
  input  logic         b_wr_rd,
  input  logic         b_en,
  input  logic         b_mb,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] b_dout,
  output logic         b_dout_oe,
  output logic         b_f2_wr,
  input  logic         b_f2_in_rdy,
  output logic         b_f1_rd,
  input  logic         b_f1_out_rdy,
  input  logic [W-1:0] b_f1_rdata,
  output logic         b_mb1_full
);
  port_op_t     op_a, op_b;
  logic [W-1:0] mail1_q, mail2_q;

  port_decode #(.WR_LEVEL(1'b1)) u_dec_a (
    .clk(clk_a), .rst(rst_a), .cs_n(a_cs_n), .wr_rd(a_wr_rd), .en(a_en),
    .mb(a_mb), .in_rdy(a_f1_in_rdy), .out_rdy(a_f2_out_rdy), .op(op_a));

  port_decode #(.WR_LEVEL(1'b0)) u_dec_b (
    .clk(clk_b), .rst(rst_b), .cs_n(b_cs_n), .wr_rd(b_wr_rd), .en(b_en),
    .mb(b_mb), .in_rdy(b_f2_in_rdy), .out_rdy(b_f1_out_rdy), .op(op_b));

  mailbox_xfer #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_mail1 (
    .wclk(clk_a), .wrst(rst_a), .wr_req(op_a.mail_wr), .wdata(a_din),
    .rclk(clk_b), .rrst(rst_b), .rd_req(op_b.mail_rd),
    .rdata(mail1_q), .rfull(b_mb1_full));

  mailbox_xfer #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_mail2 (
    .wclk(clk_b), .wrst(rst_b), .wr_req(op_b.mail_wr), .wdata(b_din),
    .rclk(clk_a), .rrst(rst_a), .rd_req(op_a.mail_rd),
    .rdata(mail2_q), .rfull(a_mb2_full));

  assign a_f1_wr   = op_a.fifo_wr;
  assign a_f2_rd   = op_a.fifo_rd;
  assign a_dout_oe = op_a.drive;
  assign a_dout    = !op_a.drive ? '0 : (a_mb ? mail2_q : a_f2_rdata);

  assign b_f2_wr   = op_b.fifo_wr;
  assign b_f1_rd   = op_b.fifo_rd;
  assign b_dout_oe = op_b.drive;
  assign b_dout    = !op_b.drive ? '0 : (b_mb ? mail1_q : b_f1_rdata);
endmodule

// File: tb/bidir_port_ctrl_tb.sv
module bidir_port_ctrl_tb;
  localparam int W = 36;
  localparam logic [W-1:0] RD_A = 36'h5_0A0A_0A0A;
  localparam logic [W-1:0] RD_B = 36'h3_0B0B_0B0B;

  logic clk_a = 0, clk_b = 0, rst_a = 1, rst_b = 1;
  logic a_cs_n = 1, a_wr_rd = 0, a_en = 0, a_mb = 0, a_f1_in_rdy = 0, a_f2_out_rdy = 0;
  logic b_cs_n = 1, b_wr_rd = 1, b_en = 0, b_mb = 0, b_f2_in_rdy = 0, b_f1_out_rdy = 0;
  logic [W-1:0] a_din = '0, b_din = '0, a_f2_rdata = RD_A, b_f1_rdata = RD_B;
  logic [W-1:0] a_dout, b_dout;
  logic a_dout_oe, b_dout_oe, a_f1_wr, a_f2_rd, b_f2_wr, b_f1_rd, a_mb2_full, b_mb1_full;
  int checks = 0, errors = 0;

  always #10 clk_a = ~clk_a;
  initial begin #7; forever #13 clk_b = ~clk_b; end

  bidir_port_ctrl #(.W(W), .SYNC_STAGES(2)) u_dut (
    .clk_a(clk_a), .rst_a(rst_a), .a_cs_n(a_cs_n), .a_wr_rd(a_wr_rd), .a_en(a_en),
    .a_mb(a_mb), .a_din(a_din), .a_dout(a_dout), .a_dout_oe(a_dout_oe),
    .a_f1_wr(a_f1_wr), .a_f1_in_rdy(a_f1_in_rdy), .a_f2_rd(a_f2_rd),
    .a_f2_out_rdy(a_f2_out_rdy), .a_f2_rdata(a_f2_rdata), .a_mb2_full(a_mb2_full),
    .clk_b(clk_b), .rst_b(rst_b), .b_cs_n(b_cs_n), .b_wr_rd(b_wr_rd), .b_en(b_en),
    .b_mb(b_mb), .b_din(b_din), .b_dout(b_dout), .b_dout_oe(b_dout_oe),
    .b_f2_wr(b_f2_wr), .b_f2_in_rdy(b_f2_in_rdy), .b_f1_rd(b_f1_rd),
    .b_f1_out_rdy(b_f1_out_rdy), .b_f1_rdata(b_f1_rdata), .b_mb1_full(b_mb1_full));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_a);
    rst_a = 1; rst_b = 1;
    repeat (6) @(negedge clk_a);
    rst_a = 0; rst_b = 0;
  endtask

  task automatic a_access(input bit wr, input bit mb, input logic [W-1:0] d, output logic [W-1:0] q);
    @(negedge clk_a);
    a_cs_n = 0; a_wr_rd = wr; a_en = 1; a_mb = mb; a_din = d;
    #1 q = a_dout;
    @(negedge clk_a);
    a_cs_n = 1; a_en = 0; a_mb = 0;
  endtask

  task automatic b_access(input bit wr, input bit mb, input logic [W-1:0] d, output logic [W-1:0] q);
    @(negedge clk_b);
    b_cs_n = 0; b_wr_rd = !wr; b_en = 1; b_mb = mb; b_din = d;
    #1 q = b_dout;
    @(negedge clk_b);
    b_cs_n = 1; b_en = 0; b_mb = 0;
  endtask

  task automatic wait_b_flag(output bit seen);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_b);
      if (b_mb1_full) begin seen = 1; break; end
    end
  endtask

  task automatic wait_a_flag(output bit seen);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_a);
      if (a_mb2_full) begin seen = 1; break; end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk_a);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] q, va, vb;
    bit seen;
    do_reset();
    @(negedge clk_b);
    // R10 reset state
    check(!a_mb2_full && !b_mb1_full, "R10 flags", {a_mb2_full, b_mb1_full}, 0);

    // Exhaustive decode sweep, port A (din stays 0, so mail stays 0)
    for (int v = 0; v < 64; v++) begin
      logic sel, wr, ef1, ef2, eoe;
      logic [W-1:0] edout;
      @(negedge clk_a);
      {a_cs_n, a_wr_rd, a_en, a_mb, a_f1_in_rdy, a_f2_out_rdy} = v[5:0];
      #1;
      sel = !a_cs_n; wr = a_wr_rd;
      ef1 = sel && a_en && wr && !a_mb && a_f1_in_rdy;
      ef2 = sel && a_en && !wr && !a_mb && a_f2_out_rdy;
      eoe = sel && !wr;
      edout = eoe ? (a_mb ? '0 : RD_A) : '0;
      check(a_f1_wr == ef1, "R1", a_f1_wr, ef1);
      check(a_f2_rd == ef2, "R2", a_f2_rd, ef2);
      check(a_dout_oe == eoe && a_dout == edout, "R4 R5 port A", {a_dout_oe, a_dout}, {eoe, edout});
    end
    @(negedge clk_a); a_cs_n = 1; a_en = 0; a_mb = 0;

    // Exhaustive decode sweep, port B (inverted direction)
    for (int v = 0; v < 64; v++) begin
      logic sel, wr, ef2, ef1, eoe;
      logic [W-1:0] edout;
      @(negedge clk_b);
      {b_cs_n, b_wr_rd, b_en, b_mb, b_f2_in_rdy, b_f1_out_rdy} = v[5:0];
      #1;
      sel = !b_cs_n; wr = !b_wr_rd;
      ef2 = sel && b_en && wr && !b_mb && b_f2_in_rdy;
      ef1 = sel && b_en && !wr && !b_mb && b_f1_out_rdy;
      eoe = sel && !wr;
      edout = eoe ? (b_mb ? '0 : RD_B) : '0;
      check(b_f2_wr == ef2, "R3 write", b_f2_wr, ef2);
      check(b_f1_rd == ef1, "R3 read", b_f1_rd, ef1);
      check(b_dout_oe == eoe && b_dout == edout, "R4 R5 port B", {b_dout_oe, b_dout}, {eoe, edout});
    end
    @(negedge clk_b); b_cs_n = 1; b_en = 0; b_mb = 0;

    do_reset();
    repeat (3) @(negedge clk_b);
    check(!b_mb1_full && !a_mb2_full, "R10 after second reset", {a_mb2_full, b_mb1_full}, 0);

    // Mailbox 1: set, ignored overwrite, clear, held word
    a_access(1, 1, 36'h1_2345_6789, q);
    repeat (4) @(negedge clk_b);
    check(b_mb1_full, "R6 flag set", b_mb1_full, 1);
    a_access(1, 1, 36'hF_FFFF_0000, q);
    repeat (5) @(negedge clk_b);
    b_access(0, 1, '0, q);
    check(q == 36'h1_2345_6789, "R8 old word kept", q, 36'h1_2345_6789);
    check(!b_mb1_full, "R7 flag cleared", b_mb1_full, 0);
    b_access(0, 1, '0, q);
    check(q == 36'h1_2345_6789, "R7 word still valid", q, 36'h1_2345_6789);
    check(!b_mb1_full, "R7 flag stays low", b_mb1_full, 0);
    repeat (5) @(negedge clk_a);
    a_access(1, 1, 36'h0_CAFE_0003, q);
    wait_b_flag(seen);
    check(seen, "R9 flag after rewrite", seen, 1);
    b_access(0, 1, '0, q);
    check(q == 36'h0_CAFE_0003, "R9 new word", q, 36'h0_CAFE_0003);

    // Ping-pong both directions
    for (int i = 0; i < 6; i++) begin
      va = 36'h0_A5A5_0000 + W'(i * 37);
      vb = ~va;
      repeat (5) @(negedge clk_a);
      a_access(1, 1, va, q);
      wait_b_flag(seen);
      check(seen, "R6 ping flag", seen, 1);
      b_access(0, 1, '0, q);
      check(q == va, "R9 ping word", q, va);
      repeat (5) @(negedge clk_b);
      b_access(1, 1, vb, q);
      wait_a_flag(seen);
      check(seen, "R6 pong flag", seen, 1);
      a_access(0, 1, '0, q);
      check(q == vb, "R5 R9 pong word", q, vb);
      @(negedge clk_a);
      check(!a_mb2_full, "R7 pong flag cleared", a_mb2_full, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule